// File: doc/BRIEF.md
# Collision Retry and Partition Controller

This block sits beside a half-duplex Ethernet transmitter and decides what happens after each collision. For every frame it counts retransmission attempts against a programmable ceiling. It answers each collision with either a retry pulse or a give-up pulse. It also keeps the collision counter that feeds the random backoff logic, and it restarts that counter after a selectable number of consecutive trials. When the frame ends, the block reports a per-frame status word. The random slot generator and the MAC datapath are outside this block.

The block also watches collisions across frames. When partitioning is enabled and too many collisions accumulate without a successful transmission, the port enters a partition state. In that state it keeps transmitting but drops receive traffic. The first good frame seen on the wire returns the port to normal.

All decision and status outputs are registered and appear one clock after the strobe that causes them. The receive pass-through `rx_pass` is combinational.

Top module: `coll_retry_ctrl`

## Requirements
- R1: While `rst_n` is low and right after reset, `retry`, `give_up`, `status_valid`, `partitioned` and `bo_count` are all 0.
- R2: A normal collision (`collision`=1 with `late_coll`=0) inside an open frame, while retries remain, pulses `retry` one cycle later. Each retry adds one to the frame's retry count, and `frame_start` clears that count to 0.
- R3: With `retry_limit` N in 1..15, the collision that arrives after N retries pulses `give_up` and `status_valid` together, in place of `retry`. The status then shows `st_rlim`=1, `st_coll`=1 and `st_rcnt`=N. The frame closes, and a later `tx_done` produces no status.
- R4: With `retry_limit`=0, every normal collision is retried. The 4-bit retry count in the status saturates at 15.
- R5: `bo_count`, valid in the cycle `retry` is high, is the number of retries since the last restart. With `trial_win4`=0 it runs 1..15 and then 0 on the 16th retry. With `trial_win4`=1 it runs 1,2,3 and then 0 on the 4th retry. `frame_start` clears it.
- R6: A late collision (`late_coll`=1) produces neither `retry` nor `give_up`. It sets `st_late` and `st_coll` in the frame's status.
- R7: `tx_done` in an open frame pulses `status_valid` one cycle later. The fields are `st_late`, `st_urun` (an `underrun` strobe seen during the frame), `st_rlim`=0, `st_coll` (any collision in the frame) and `st_rcnt` (the retry count). `st_err` equals `st_late | st_urun | st_rlim`.
- R8: `abort` closes the frame at once. It writes no status, and later collisions and `tx_done` are ignored until the next `frame_start`.
- R9: With `part_en`=1, the 62nd collision counted since the last clear sets `partitioned` one cycle later. With `part_en`=0, `partitioned` stays 0 whatever the count.
- R10: While `partitioned`=1, `rx_pass` is 0 even when `rx_good`=1, and collisions are still retried. A `rx_good` strobe while partitioned clears `partitioned` and the collision count on the next edge.
- R11: A `tx_done` with no late collision and no underrun in the frame clears the partition collision count.
- R12: `collision` and `tx_done` outside an open frame have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Strobe: a new frame begins |
| collision | input | 1 | Strobe: collision seen on the current attempt |
| late_coll | input | 1 | Qualifies `collision` as late (after the first 64 bytes) |
| underrun | input | 1 | Strobe: transmit underrun in the current frame |
| tx_done | input | 1 | Strobe: frame transmission finished |
| abort | input | 1 | Strobe: abandon the current frame without status |
| rx_good | input | 1 | Strobe: good frame received on the wire |
| retry_limit | input | 4 | Maximum retransmissions per frame, 0 = unlimited |
| trial_win4 | input | 1 | 1: restart backoff counter after 4 trials, 0: after 16 |
| part_en | input | 1 | Enable partition on excessive collisions |
| retry | output | 1 | Pulse: retransmit after backoff |
| give_up | output | 1 | Pulse: retry limit hit, frame dropped |
| bo_count | output | 4 | Collision counter handed to the backoff logic |
| status_valid | output | 1 | Pulse: status fields below are valid |
| st_late | output | 1 | Status: late collision |
| st_urun | output | 1 | Status: underrun |
| st_rlim | output | 1 | Status: retry limit reached |
| st_coll | output | 1 | Status: at least one collision |
| st_rcnt | output | 4 | Status: retry count |
| st_err | output | 1 | Status: error summary |
| partitioned | output | 1 | Port is in partition state |
| rx_pass | output | 1 | `rx_good` passed through when not partitioned |

## Verification
The bench goes after the exact collision on which the limit bites. A design that compares with the wrong bound retries once too often or gives up one retry early, and the retry count reported in the status moves with it. The backoff counter's wrap is checked for both trial windows, together with saturation of the retry count in unlimited mode. A wrong window length shows up as a `bo_count` that reaches 4 or that wraps at 15. The partition threshold is probed at 61 and 62 collisions, with a successful frame placed in between so that a design that fails to clear the count partitions too early. The bench also confirms that abort leaves no status behind, and that a stray `tx_done` after give-up produces none either.

// File: rtl/crp_pkg.sv
package crp_pkg;
  localparam int RC_W = 4;

  typedef struct packed {
    logic            late;
    logic            urun;
    logic            rlim;
    logic            coll;
    logic [RC_W-1:0] rcnt;
  } frame_stat_t;
endpackage

// File: rtl/crp_retry_tracker.sv
module crp_retry_tracker #(
  parameter int RC_W      = 4,
  parameter int WIN_LONG  = 16,
  parameter int WIN_SHORT = 4,
  localparam int BO_W     = $clog2(WIN_LONG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            hit,
  input  logic [RC_W-1:0] limit,
  input  logic            win_short,
  output logic            allow,
  output logic [RC_W-1:0] attempts,
  output logic [BO_W-1:0] bo
);
  localparam logic [RC_W-1:0] RC_SAT = '1;

  logic [RC_W-1:0] att_d;
  logic [BO_W-1:0] bo_d;
  logic [BO_W-1:0] bo_last;
  logic            en;

  always_comb begin
    allow   = (limit == '0) || (attempts < limit);
    bo_last = win_short ? BO_W'(WIN_SHORT - 1) : BO_W'(WIN_LONG - 1);
    att_d   = attempts;
    bo_d    = bo;
    en      = 1'b0;
    if (clr) begin
      att_d = '0;
      bo_d  = '0;
      en    = 1'b1;
    end else if (hit && allow) begin
      en = 1'b1;
      if (attempts != RC_SAT) att_d = attempts + 1'b1;
      bo_d = (bo >= bo_last) ? '0 : bo + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      attempts <= '0;
      bo       <= '0;
    end else if (en) begin
      attempts <= att_d;
      bo       <= bo_d;
    end
  end
endmodule

// File: rtl/crp_part_monitor.sv
module crp_part_monitor #(
  parameter int THRESH = 62,
  localparam int CW    = $clog2(THRESH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic coll_ev,
  input  logic tx_ok,
  input  logic rx_good,
  input  logic enable,
  output logic partitioned
);
  localparam logic [CW-1:0] CNT_SAT = '1;

  logic [CW-1:0] cnt, cnt_d;
  logic          part_d;

  always_comb begin
    cnt_d  = cnt;
    part_d = partitioned;
    if (partitioned && rx_good) begin
      part_d = 1'b0;
      cnt_d  = '0;
    end else begin
      if (tx_ok) cnt_d = '0;
      else if (coll_ev && cnt != CNT_SAT) cnt_d = cnt + 1'b1;
      if (enable && cnt_d >= CW'(THRESH)) part_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt         <= '0;
      partitioned <= 1'b0;
    end else begin
      cnt         <= cnt_d;
      partitioned <= part_d;
    end
  end
endmodule

// File: rtl/coll_retry_ctrl.sv
module coll_retry_ctrl
  import crp_pkg::*;
#(
  parameter int PART_THRESH = 62,
  parameter int WIN_LONG    = 16,
  parameter int WIN_SHORT   = 4,
  localparam int BO_W       = $clog2(WIN_LONG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_start,
  input  logic            collision,
  input  logic            late_coll,
  input  logic            underrun,
  input  logic            tx_done,
  input  logic            abort,
  input  logic            rx_good,
  input  logic [RC_W-1:0] retry_limit,
  input  logic            trial_win4,
  input  logic            part_en,
  output logic            retry,
  output logic            give_up,
  output logic [BO_W-1:0] bo_count,
  output logic            status_valid,
  output logic            st_late,
  output logic            st_urun,
  output logic            st_rlim,
  output logic            st_coll,
  output logic [RC_W-1:0] st_rcnt,
  output logic            st_err,
  output logic            partitioned,
  output logic            rx_pass
);
  logic            active, active_d;
  logic            late_s, late_d, urun_s, urun_d, coll_s, coll_d;
  logic            retry_d, give_d, sv_d;
  frame_stat_t     stat_q, stat_d;
  logic            allow;
  logic [RC_W-1:0] attempts;
  logic            live, trk_clr, trk_hit, coll_ev, tx_ok;

  assign live    = active && !abort && !frame_start;
  assign trk_clr = frame_start && !abort;
  assign trk_hit = live && collision && !late_coll;
  assign coll_ev = live && collision;
  assign tx_ok   = live && !collision && tx_done && !late_s && !urun_s && !underrun;

  crp_retry_tracker #(
    .RC_W(RC_W), .WIN_LONG(WIN_LONG), .WIN_SHORT(WIN_SHORT)
  ) trk_i (
    .clk(clk), .rst_n(rst_n), .clr(trk_clr), .hit(trk_hit),
    .limit(retry_limit), .win_short(trial_win4),
    .allow(allow), .attempts(attempts), .bo(bo_count)
  );

  crp_part_monitor #(.THRESH(PART_THRESH)) part_i (
    .clk(clk), .rst_n(rst_n), .coll_ev(coll_ev), .tx_ok(tx_ok),
    .rx_good(rx_good), .enable(part_en), .partitioned(partitioned)
  );

  always_comb begin
    active_d = active;
    late_d   = late_s;
    urun_d   = urun_s;
    coll_d   = coll_s;
    retry_d  = 1'b0;
    give_d   = 1'b0;
    sv_d     = 1'b0;
    stat_d   = stat_q;
    if (abort) begin
      active_d = 1'b0;
    end else if (frame_start) begin
      active_d = 1'b1;
      late_d   = 1'b0;
      urun_d   = 1'b0;
      coll_d   = 1'b0;
    end else if (active) begin
      if (underrun) urun_d = 1'b1;
      if (collision) begin
        coll_d = 1'b1;
        if (late_coll) begin
          late_d = 1'b1;
        end else if (allow) begin
          retry_d = 1'b1;
        end else begin
          give_d      = 1'b1;
          sv_d        = 1'b1;
          active_d    = 1'b0;
          stat_d.late = late_d;
          stat_d.urun = urun_d;
          stat_d.rlim = 1'b1;
          stat_d.coll = 1'b1;
          stat_d.rcnt = attempts;
        end
      end else if (tx_done) begin
        sv_d        = 1'b1;
        active_d    = 1'b0;
        stat_d.late = late_d;
        stat_d.urun = urun_d;
        stat_d.rlim = 1'b0;
        stat_d.coll = coll_d;
        stat_d.rcnt = attempts;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active       <= 1'b0;
      late_s       <= 1'b0;
      urun_s       <= 1'b0;
      coll_s       <= 1'b0;
      retry        <= 1'b0;
      give_up      <= 1'b0;
      status_valid <= 1'b0;
      stat_q       <= '0;
    end else begin
      active       <= active_d;
      late_s       <= late_d;
      urun_s       <= urun_d;
      coll_s       <= coll_d;
      retry        <= retry_d;
      give_up      <= give_d;
      status_valid <= sv_d;
      if (sv_d) stat_q <= stat_d;
    end
  end

  assign st_late = stat_q.late;
  assign st_urun = stat_q.urun;
  assign st_rlim = stat_q.rlim;
  assign st_coll = stat_q.coll;
  assign st_rcnt = stat_q.rcnt;
  assign st_err  = stat_q.late | stat_q.urun | stat_q.rlim;
  assign rx_pass = rx_good && !partitioned;
endmodule

// File: rtl/crp_checker.sv
module crp_checker (
  input logic clk,
  input logic rst_n,
  input logic collision,
  input logic late_coll,
  input logic tx_done,
  input logic abort,
  input logic part_en,
  input logic retry,
  input logic give_up,
  input logic status_valid,
  input logic st_rlim,
  input logic partitioned,
  input logic rx_pass
);
  assert_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(retry && give_up));

  assert_giveup_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    give_up |-> (status_valid && st_rlim));

  assert_retry_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    retry |-> ($past(collision) && !$past(late_coll) && !$past(abort)));

  assert_status_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    status_valid |-> ($past(tx_done) || $past(collision)));

  assert_abort_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!status_valid && !retry && !give_up));

  assert_part_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(partitioned) |-> $past(part_en));

  assert_rx_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
    partitioned |-> !rx_pass);
endmodule

bind coll_retry_ctrl crp_checker chk_i (
  .clk(clk), .rst_n(rst_n), .collision(collision), .late_coll(late_coll),
  .tx_done(tx_done), .abort(abort), .part_en(part_en), .retry(retry),
  .give_up(give_up), .status_valid(status_valid), .st_rlim(st_rlim),
  .partitioned(partitioned), .rx_pass(rx_pass)
);

// File: tb/coll_retry_ctrl_tb.sv
module coll_retry_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       frame_start, collision, late_coll, underrun, tx_done, abort, rx_good;
  logic [3:0] retry_limit;
  logic       trial_win4, part_en;
  logic       retry, give_up, status_valid;
  logic [3:0] bo_count, st_rcnt;
  logic       st_late, st_urun, st_rlim, st_coll, st_err, partitioned, rx_pass;

  int checks = 0;
  int fails  = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  // model state
  logic       m_active;
  logic [3:0] m_att, m_bo;
  logic       m_late, m_urun, m_coll;

  always #(CLK_PERIOD/2) clk = ~clk;

  coll_retry_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .collision(collision),
    .late_coll(late_coll), .underrun(underrun), .tx_done(tx_done), .abort(abort),
    .rx_good(rx_good), .retry_limit(retry_limit), .trial_win4(trial_win4),
    .part_en(part_en), .retry(retry), .give_up(give_up), .bo_count(bo_count),
    .status_valid(status_valid), .st_late(st_late), .st_urun(st_urun),
    .st_rlim(st_rlim), .st_coll(st_coll), .st_rcnt(st_rcnt), .st_err(st_err),
    .partitioned(partitioned), .rx_pass(rx_pass)
  );

  function automatic logic [15:0] mk(logic r, logic g, logic sv, logic [3:0] bo,
                                     logic rl, logic lt, logic ur, logic cl,
                                     logic [3:0] rc);
    return {r, g, sv, bo, rl, lt, ur, cl, (lt | ur | rl), rc};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected events as the design emits them
  always @(negedge clk) begin
    if (rst_n && (retry || give_up || status_valid)) begin
      logic [15:0] obs;
      obs = {retry, give_up, status_valid, (retry ? bo_count : 4'd0),
             (status_valid ? {st_rlim, st_late, st_urun, st_coll, st_err, st_rcnt} : 9'd0)};
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL unexpected event (R8/R12): actual %0h expected none", obs);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (obs !== e) begin
          fails++;
          $display("FAIL %s: actual %0h expected %0h", t, obs, e);
        end
      end
    end
  end

  task automatic start_frame();
    frame_start = 1'b1;
    m_active = 1'b1; m_att = '0; m_bo = '0;
    m_late = 1'b0; m_urun = 1'b0; m_coll = 1'b0;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic hit(logic late, string tag);
    collision = 1'b1;
    late_coll = late;
    if (m_active) begin
      m_coll = 1'b1;
      if (late) m_late = 1'b1;
      else if (retry_limit == 0 || m_att < retry_limit) begin
        if (m_att != 4'd15) m_att++;
        m_bo = (m_bo >= (trial_win4 ? 4'd3 : 4'd15)) ? 4'd0 : m_bo + 4'd1;
        exp_q.push_back(mk(1, 0, 0, m_bo, 0, 0, 0, 0, 0));
        tag_q.push_back(tag);
      end else begin
        exp_q.push_back(mk(0, 1, 1, 0, 1, m_late, m_urun, 1, m_att));
        tag_q.push_back(tag);
        m_active = 1'b0;
      end
    end
    @(negedge clk);
    collision = 1'b0;
    late_coll = 1'b0;
  endtask

  task automatic hits(int n, string tag);
    for (int i = 0; i < n; i++) hit(1'b0, tag);
  endtask

  task automatic mark_urun();
    underrun = 1'b1;
    if (m_active) m_urun = 1'b1;
    @(negedge clk);
    underrun = 1'b0;
  endtask

  task automatic finish_tx(string tag);
    tx_done = 1'b1;
    if (m_active) begin
      exp_q.push_back(mk(0, 0, 1, 0, 0, m_late, m_urun, m_coll, m_att));
      tag_q.push_back(tag);
      m_active = 1'b0;
    end
    @(negedge clk);
    tx_done = 1'b0;
  endtask

  task automatic do_abort();
    abort = 1'b1;
    m_active = 1'b0;
    @(negedge clk);
    abort = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    frame_start = 0; collision = 0; late_coll = 0; underrun = 0;
    tx_done = 0; abort = 0; rx_good = 0;
    retry_limit = 4'd3; trial_win4 = 1'b0; part_en = 1'b0;
    m_active = 0; m_att = 0; m_bo = 0; m_late = 0; m_urun = 0; m_coll = 0;
    repeat (3) @(negedge clk);
    check("R1 outputs in reset", {retry, give_up, status_valid, partitioned, bo_count}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 outputs after reset", {retry, give_up, status_valid, partitioned, bo_count}, 0);

    // R2/R7: two retries then clean completion
    start_frame();
    hits(2, "R2 retry");
    finish_tx("R7 status after retries");

    // R3: limit 3, fourth collision gives up; late tx_done ignored (R12)
    start_frame();
    hits(3, "R3 retries before limit");
    hit(1'b0, "R3 give-up");
    finish_tx("R12 ignored");
    start_frame();
    hit(1'b0, "R2 count cleared");
    finish_tx("R2 status rcnt 1");

    // R5: 4-trial window; R4: unlimited with saturation, 16-trial window
    retry_limit = 4'd0; trial_win4 = 1'b1;
    start_frame();
    hits(6, "R5 window of 4");
    finish_tx("R5 status");
    trial_win4 = 1'b0;
    start_frame();
    hits(17, "R4 R5 window of 16");
    finish_tx("R4 saturated count");

    // R6/R7: late collision, underrun
    retry_limit = 4'd2;
    start_frame();
    hit(1'b1, "R6 late no retry");
    hit(1'b0, "R6 retry after late");
    mark_urun();
    finish_tx("R6 R7 late and underrun status");

    // R8: abort silences the frame
    start_frame();
    hit(1'b0, "R8 retry before abort");
    do_abort();
    hit(1'b0, "R8 after abort");
    finish_tx("R8 after abort");
    repeat (2) @(negedge clk);
    check("R8 nothing pending after abort", exp_q.size(), 0);

    // R12: collision with no open frame
    hit(1'b0, "R12 idle collision");
    @(negedge clk);
    check("R12 idle collision no event", {retry, give_up, exp_q.size() == 0}, 3'b001);

    // R9: disabled partition
    retry_limit = 4'd0; part_en = 1'b0;
    start_frame();
    hits(62, "R9 disabled run");
    check("R9 disabled no partition", partitioned, 0);
    finish_tx("R11 clean done");

    // R11/R9/R10: enabled partition
    part_en = 1'b1;
    start_frame();
    hits(40, "R11 first batch");
    finish_tx("R11 clears count");
    start_frame();
    hits(30, "R11 second batch");
    check("R11 count was cleared", partitioned, 0);
    hits(31, "R9 approach");
    check("R9 61 collisions", partitioned, 0);
    hit(1'b0, "R9 62nd");
    check("R9 62nd collision partitions", partitioned, 1);
    hit(1'b0, "R10 tx still retried");
    rx_good = 1'b1;
    #1;
    check("R10 rx blocked", rx_pass, 0);
    @(negedge clk);
    rx_good = 1'b0;
    check("R10 exit on good frame", partitioned, 0);
    rx_good = 1'b1;
    #1;
    check("R10 rx passes after exit", rx_pass, 1);
    @(negedge clk);
    rx_good = 1'b0;
    hit(1'b0, "R10 count cleared on exit");
    check("R10 no re-partition", partitioned, 0);
    finish_tx("R10 final status");

    repeat (3) @(negedge clk);
    check("all expected events seen", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule